// File: doc/BRIEF.md
# Dual External Interrupt Request Detector

This block turns two active-low external interrupt pins into two interrupt request flags for a small 8-bit controller core. Each source has a trigger-mode bit. In falling-edge mode a high-to-low transition of the synchronised pin latches the request flag. In low-level mode the flag simply mirrors the inverted synchronised pin. The mode bits and the request flags share one 4-bit control field that software reads and writes.

The interrupt controller pulses a per-source service acknowledge when it enters a handler. That pulse clears an edge-mode flag and has no effect on a level-mode flag. A level-mode source that still holds its pin low after its handler returns therefore requests service again.

A combinational wake output reports any pin held low, so the power-down logic can restart the clock without needing one. Pin routing, priority, vectors and clock control sit outside this block. No data stream crosses its edge, so every port is a plain control or status pin.

Top module: `xirq_detect`

## Requirements
- R1: While reset is asserted and right after it, `ctl_rdata` and `irq_req` are all zero, which means both sources are in level mode with no request.
- R2: The control field uses a fixed bit order: bit 0 is the trigger mode of source 0, bit 1 is the flag of source 0, bit 2 is the trigger mode of source 1, and bit 3 is the flag of source 1. A mode bit of 1 selects falling-edge detection and 0 selects low-level detection. When `ctl_wr` is high at a clock edge, that edge loads the mode bits from `ctl_wdata`.
- R3: In edge mode, each pin passes through two synchroniser flops, then a one-flop previous-sample stage. Let edge A be the first clock edge that samples the pin low after it was sampled high. The source's flag reads 1 after edge A+2, and `irq_req` shows the same value.
- R4: An edge-mode flag holds its value when there is no new falling edge, no write and no acknowledge. A rising edge never sets it. A pin held low does not set it again.
- R5: In edge mode, an acknowledge clears the flag at the next edge. If a falling edge is detected in the same cycle as the acknowledge, the flag ends up set.
- R6: In edge mode, a software write loads each flag bit from `ctl_wdata`: 1 sets it and 0 clears it.
- R7: In level mode, the flag after each clock edge equals the inverse of the synchronised pin before that edge. A pin change is therefore seen after the same three edges as in R3.
- R8: In level mode, software writes to a flag bit have no effect. The flag keeps following the pin.
- R9: In level mode, the acknowledge is ignored. A pin still held low keeps the request asserted after service.
- R10: `wake` is 1 whenever either raw pin is low, and it responds without any clock edge.
- R11: In a cycle with a write, each flag follows the rule of the mode that was held before that write. A write that leaves edge mode loads the written flag bit. A write that enters edge mode loads the inverted pin.
- R12: Edge detection is suppressed until three clock edges after reset release, so that a pin held low through reset never raises a false edge request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_n | input | 2 | Raw active-low interrupt pins, bit i is source i |
| ctl_wr | input | 1 | Control field write strobe |
| ctl_wdata | input | 4 | Control field write data |
| ctl_rdata | output | 4 | Control field read data |
| svc_ack | input | 2 | Service-entry acknowledge pulse, bit i is source i |
| irq_req | output | 2 | Request flags presented to the interrupt controller |
| wake | output | 1 | Asynchronous wake request, high while any pin is low |

## Verification
The bench aims at the points where the two trigger modes differ. An acknowledge that lands in the same cycle as a new edge must not lose the request; a design that gives the acknowledge priority drops that interrupt. Level-mode flags must ignore both the acknowledge and software clears; a design that lets either through hides a source that is still holding its pin low.

The bench also drives writes that switch modes, to pin down which rule applies in that cycle. It holds a pin low through reset and then selects edge mode; a design whose previous-sample stage is not primed reports a phantom falling edge. Finally it checks that a rising edge or a long low level never re-arms an edge-mode flag, and that `wake` moves with no clock edge at all.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;

  localparam int FIELDS_PER_SRC = 2;
  localparam int MODE_OFS       = 0;
  localparam int FLAG_OFS       = 1;

  function automatic int mode_pos(input int src);
    return src * FIELDS_PER_SRC + MODE_OFS;
  endfunction

  function automatic int flag_pos(input int src);
    return src * FIELDS_PER_SRC + FLAG_OFS;
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/xirq_arm.sv
module xirq_arm #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic armed
);

  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt != CW'(SETTLE)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign armed = (cnt == CW'(SETTLE));

endmodule

// File: rtl/xirq_chan.sv
module xirq_chan
  import xirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  armed,
  input  logic  lvl_sync,
  input  logic  wr_en,
  input  logic  wr_mode,
  input  logic  wr_flag,
  input  logic  ack,
  output trig_e mode,
  output logic  flag,
  output logic  fall
);

  logic prev_q;
  logic flag_nxt;

  always_comb begin
    fall = armed && (mode == TRIG_FALL) && prev_q && !lvl_sync;
    if (mode == TRIG_LEVEL) begin
      flag_nxt = !lvl_sync;
    end else if (fall) begin
      flag_nxt = 1'b1;
    end else if (wr_en) begin
      flag_nxt = wr_flag;
    end else if (ack) begin
      flag_nxt = 1'b0;
    end else begin
      flag_nxt = flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      mode   <= TRIG_LEVEL;
      flag   <= 1'b0;
    end else begin
      prev_q <= lvl_sync;
      flag   <= flag_nxt;
      if (wr_en) begin
        mode <= trig_e'(wr_mode);
      end
    end
  end

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
#(
  parameter int N_SRC       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SRC-1:0]              pin_n,
  input  logic                          ctl_wr,
  input  logic [N_SRC*FIELDS_PER_SRC-1:0] ctl_wdata,
  output logic [N_SRC*FIELDS_PER_SRC-1:0] ctl_rdata,
  input  logic [N_SRC-1:0]              svc_ack,
  output logic [N_SRC-1:0]              irq_req,
  output logic                          wake
);

  localparam int SETTLE = SYNC_STAGES + 1;

  logic             armed;
  logic [N_SRC-1:0] sync_q;
  logic [N_SRC-1:0] fall;
  logic [N_SRC-1:0] flag_q;
  trig_e            mode_q [N_SRC];

  xirq_arm #(.SETTLE(SETTLE)) u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (armed)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    xirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_n[i]),
      .q     (sync_q[i])
    );

    xirq_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (armed),
      .lvl_sync (sync_q[i]),
      .wr_en    (ctl_wr),
      .wr_mode  (ctl_wdata[mode_pos(i)]),
      .wr_flag  (ctl_wdata[flag_pos(i)]),
      .ack      (svc_ack[i]),
      .mode     (mode_q[i]),
      .flag     (flag_q[i]),
      .fall     (fall[i])
    );

    assign ctl_rdata[mode_pos(i)] = mode_q[i];
    assign ctl_rdata[flag_pos(i)] = flag_q[i];
    assign irq_req[i]             = flag_q[i];
  end

  assign wake = !(&pin_n);

endmodule

// File: rtl/xirq_detect_chk.sv
module xirq_detect_chk #(
  parameter int N_SRC = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ctl_wr,
  input logic [2*N_SRC-1:0]     ctl_wdata,
  input logic [2*N_SRC-1:0]     ctl_rdata,
  input logic [N_SRC-1:0]       svc_ack,
  input logic [N_SRC-1:0]       sync_q,
  input logic [N_SRC-1:0]       fall
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> ctl_rdata[2*i] == $past(ctl_wdata[2*i])); // R2

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      fall[i] |=> ctl_rdata[2*i+1]); // R3

    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[2*i] && !fall[i] && !ctl_wr && !svc_ack[i]) |=> $stable(ctl_rdata[2*i+1])); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[2*i] && svc_ack[i] && !fall[i] && !ctl_wr) |=> !ctl_rdata[2*i+1]); // R5

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[2*i] |=> ctl_rdata[2*i+1] == !$past(sync_q[i])); // R7
  end

endmodule

bind xirq_detect xirq_detect_chk #(.N_SRC(N_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .ctl_rdata (ctl_rdata),
  .svc_ack   (svc_ack),
  .sync_q    (sync_q),
  .fall      (fall)
);

// File: tb/xirq_detect_bench.sv
module xirq_detect_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_n = 2'b11;
  logic       ctl_wr = 1'b0;
  logic [3:0] ctl_wdata = 4'h0;
  logic [3:0] ctl_rdata;
  logic [1:0] svc_ack = 2'b00;
  logic [1:0] irq_req;
  logic       wake;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  xirq_detect u_xirq_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_n     (pin_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .svc_ack   (svc_ack),
    .irq_req   (irq_req),
    .wake      (wake)
  );

  // row: {pin_n[1:0], wr, wdata[3:0], ack[1:0], exp_rdata[3:0], exp_wake}
  localparam int NV = 29;
  localparam logic [13:0] VEC [NV] = '{
    14'b11_1_0101_00_0101_0,
    14'b10_0_0000_00_0101_1,
    14'b10_0_0000_00_0101_1,
    14'b11_0_0000_00_0111_0,
    14'b11_0_0000_01_0101_0,
    14'b01_0_0000_00_0101_1,
    14'b11_0_0000_00_0101_0,
    14'b11_0_0000_10_1101_0,
    14'b11_1_1111_00_1111_0,
    14'b11_1_0101_00_0101_0,
    14'b11_1_0000_00_0000_0,
    14'b10_0_0000_00_0000_1,
    14'b10_0_0000_00_0000_1,
    14'b10_0_0000_01_0010_1,
    14'b10_1_0000_00_0010_1,
    14'b11_0_0000_00_0010_0,
    14'b11_0_0000_00_0010_0,
    14'b11_0_0000_00_0000_0,
    14'b11_1_1010_00_0000_0,
    14'b11_1_0111_00_0101_0,
    14'b11_0_0000_00_0101_0,
    14'b10_0_0000_00_0101_1,
    14'b10_0_0000_00_0101_1,
    14'b10_0_0000_00_0111_1,
    14'b10_0_0000_01_0101_1,
    14'b10_0_0000_00_0101_1,
    14'b11_0_0000_00_0101_0,
    14'b11_0_0000_00_0101_0,
    14'b11_0_0000_00_0101_0
  };

  function automatic string row_req(input int r);
    case (r)
      0:                  return "R2";
      4, 7, 24:           return "R5";
      8, 9:               return "R6";
      10, 19, 20:         return "R11";
      13:                 return "R9";
      14, 18:             return "R8";
      11, 12, 15, 16, 17: return "R7";
      25, 26, 27, 28:     return "R4";
      default:            return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata", 8'(ctl_rdata), 8'h0);
    check("R1 irq", 8'(irq_req), 8'h0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 rdata after release", 8'(ctl_rdata), 8'h0);

    for (int r = 0; r < NV; r++) begin
      pin_n     = VEC[r][13:12];
      ctl_wr    = VEC[r][11];
      ctl_wdata = VEC[r][10:7];
      svc_ack   = VEC[r][6:5];
      tick();
      check(row_req(r), 8'(ctl_rdata), 8'(VEC[r][4:1]));
      check(row_req(r), 8'(irq_req), 8'({VEC[r][4], VEC[r][2]}));
      check("R10", 8'(wake), 8'(VEC[r][0]));
    end
    ctl_wr  = 1'b0;
    svc_ack = 2'b00;

    // R10: wake responds between clock edges
    #2 pin_n = 2'b01;
    #1 check("R10 async low", 8'(wake), 8'h1);
    pin_n = 2'b11;
    #1 check("R10 async high", 8'(wake), 8'h0);

    // R12: pin held low through reset, edge mode selected at once
    @(negedge clk);
    pin_n = 2'b10;
    rst_n = 1'b0;
    repeat (3) tick();
    check("R1 rdata in reset", 8'(ctl_rdata), 8'h0);
    rst_n     = 1'b1;
    ctl_wr    = 1'b1;
    ctl_wdata = 4'b0001;
    tick();
    ctl_wr = 1'b0;
    repeat (5) tick();
    check("R12 no false edge", 8'(ctl_rdata), 8'b0001);
    check("R12 no request", 8'(irq_req), 8'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule